// File: doc/BRIEF.md
# Floating-Point Shelving Buffer with Two-Port Dispatch

This block holds decoded floating-point operations until both of their source operands are available, and then sends them to four execution units: an adder, a multiplier, a divider and a square-root unit. Only two dispatch ports leave the block. The first port feeds the adder alone. The second port is shared by the multiplier, the divider and the square-root unit, so it carries at most one of their operations per cycle.

Operations arrive from an issue stage, at most two per cycle. Result tags come back on a wakeup bus, up to two per cycle, and mark matching sources as available. Each port takes the oldest entry that is ready and that it may send. The divider and the square-root unit report when they are busy, and the shared port then skips their entries. A flush empties the buffer in one cycle.

Top module: `fp_shelf_dispatch`

## Requirements
- R1: After reset the buffer is empty, neither dispatch port is valid, and `iss_ready` is high while no issue slot requests.
- R2: The adder port (`add_*`) carries only entries with unit code 2'b00. Among the ready adder entries it picks the oldest, one per cycle.
- R3: The shared port (`shr_*`) carries at most one entry per cycle, with unit code 2'b01 (multiply), 2'b10 (divide) or 2'b11 (square root). It picks the oldest eligible ready entry, even when several are ready. The adder port and the shared port may both dispatch in the same cycle.
- R4: An entry with code 2'b10 is not eligible while `div_busy` is high, and one with code 2'b11 is not eligible while `sqrt_busy` is high. The shared port then takes the next oldest eligible entry.
- R5: A wakeup tag that matches a source tag of an entry marks that source ready at the next clock edge. The entry can then dispatch in the cycle after the wakeup. A tag broadcast in the same cycle that an entry is issued is also captured.
- R6: Issue slot 0 is older than slot 1. `iss_ready` is high only when there is no flush and the free entries (counted before this cycle's dispatch) are at least the number of slots requesting. When `iss_ready` is high, every requesting slot is stored exactly once. When it is low, neither slot is stored.
- R7: While `flush` is high, no port dispatches and `iss_ready` is low. At the next edge every entry becomes invalid.
- R8: A dispatched entry leaves the buffer at the clock edge that ends its dispatch cycle. Its slot can accept a new issue from the next cycle on.
- R9: A dispatching port presents the two source tags and the destination tag that were issued with the selected entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| flush | input | 1 | Empties the buffer and blocks dispatch and issue this cycle |
| iss_valid | input | 2 | Per-slot issue request; slot 0 is older |
| iss_unit | input | 2x2 | Per-slot unit code: 00 add, 01 mul, 10 div, 11 sqrt |
| iss_src0 | input | 2xTAG_W | Per-slot first source tag |
| iss_src0_rdy | input | 2 | Per-slot first source already available |
| iss_src1 | input | 2xTAG_W | Per-slot second source tag |
| iss_src1_rdy | input | 2 | Per-slot second source already available |
| iss_dst | input | 2xTAG_W | Per-slot destination tag |
| iss_ready | output | 1 | Both requesting slots are accepted this cycle |
| wake_valid | input | WAKE_N | Per-lane wakeup broadcast valid |
| wake_tag | input | WAKE_NxTAG_W | Per-lane result tag |
| div_busy | input | 1 | Divider cannot accept an operation |
| sqrt_busy | input | 1 | Square-root unit cannot accept an operation |
| add_valid | output | 1 | Adder port dispatches this cycle |
| add_src0 | output | TAG_W | Adder port first source tag |
| add_src1 | output | TAG_W | Adder port second source tag |
| add_dst | output | TAG_W | Adder port destination tag |
| shr_valid | output | 1 | Shared port dispatches this cycle |
| shr_unit | output | 2 | Shared port target unit code |
| shr_src0 | output | TAG_W | Shared port first source tag |
| shr_src1 | output | TAG_W | Shared port second source tag |
| shr_dst | output | TAG_W | Shared port destination tag |

## Verification
Directed patterns run first. Two ready adder entries show that the adder port sends them in age order. A mixed group of multiply, divide and square-root entries shows that the shared port sends one per cycle while the adder port works in parallel. Holding each busy input shows the fallback to a younger entry. Then come wakeups that arrive a cycle after issue and wakeups that arrive in the same cycle as issue, which tell the one-cycle wakeup-to-select latency apart from a missed capture. A full buffer with a two-slot and a one-slot request checks the acceptance rule, and a flush that arrives together with an issue request checks that nothing is stored. A long random mix of issue, wakeup, busy and rare flush is then compared against a behavioural queue model on every cycle.

// File: rtl/fpd_pkg.sv
`timescale 1ns/1ps
package fpd_pkg;

   // Unit codes; the shared port reports these on shr_unit.
   typedef enum logic [1:0] {
      FU_ADD  = 2'b00,
      FU_MUL  = 2'b01,
      FU_DIV  = 2'b10,
      FU_SQRT = 2'b11
   } fu_e;

   localparam int ISSUE_N = 2;

endpackage

// File: rtl/fpd_wake_match.sv
`timescale 1ns/1ps
module fpd_wake_match #(
   parameter int TAG_W  = 6,
   parameter int WAKE_N = 2
) (
   input  logic [TAG_W-1:0]             tag,
   input  logic [WAKE_N-1:0]            wake_valid,
   input  logic [WAKE_N-1:0][TAG_W-1:0] wake_tag,
   output logic                         hit
);

   logic [WAKE_N-1:0] lane_hit;

   for (genvar w = 0; w < WAKE_N; w++) begin : g_lane
      assign lane_hit[w] = wake_valid[w] && (wake_tag[w] == tag);
   end

   assign hit = |lane_hit;

endmodule

// File: rtl/fpd_free_alloc.sv
`timescale 1ns/1ps
module fpd_free_alloc #(
   parameter int DEPTH = 16
) (
   input  logic [DEPTH-1:0]             vld,
   output logic [DEPTH-1:0]             first,
   output logic [DEPTH-1:0]             second,
   output logic [$clog2(DEPTH+1)-1:0]   free_cnt
);

   localparam int CNT_W = $clog2(DEPTH+1);

   logic [DEPTH-1:0] free_v;
   logic [DEPTH-1:0] rest;

   always_comb begin
      free_v = ~vld;
      // lowest set bit of the free vector, then the lowest of what remains
      first  = free_v & (~free_v + 1'b1);
      rest   = free_v & ~first;
      second = rest & (~rest + 1'b1);
   end

   always_comb begin
      free_cnt = '0;
      for (int i = 0; i < DEPTH; i++) begin
         free_cnt = free_cnt + CNT_W'(free_v[i]);
      end
   end

endmodule

// File: rtl/fpd_age_pick.sv
`timescale 1ns/1ps
module fpd_age_pick #(
   parameter int DEPTH = 16
) (
   input  logic [DEPTH-1:0]            elig,
   input  logic [DEPTH-1:0][DEPTH-1:0] older,
   output logic [DEPTH-1:0]            grant,
   output logic                        found,
   output logic [$clog2(DEPTH)-1:0]    idx
);

   localparam int IDX_W = $clog2(DEPTH);

   // older[i][j] set: entry j entered before entry i
   for (genvar i = 0; i < DEPTH; i++) begin : g_row
      assign grant[i] = elig[i] & ~(|(elig & older[i]));
   end

   assign found = |grant;

   always_comb begin
      idx = '0;
      for (int i = 0; i < DEPTH; i++) begin
         if (grant[i]) idx = IDX_W'(i);
      end
   end

endmodule

// File: rtl/fp_shelf_dispatch.sv
`timescale 1ns/1ps
module fp_shelf_dispatch
   import fpd_pkg::*;
#(
   parameter int DEPTH  = 16,
   parameter int TAG_W  = 6,
   parameter int WAKE_N = 2
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          flush,
   input  logic [1:0]                    iss_valid,
   input  logic [1:0][1:0]               iss_unit,
   input  logic [1:0][TAG_W-1:0]         iss_src0,
   input  logic [1:0]                    iss_src0_rdy,
   input  logic [1:0][TAG_W-1:0]         iss_src1,
   input  logic [1:0]                    iss_src1_rdy,
   input  logic [1:0][TAG_W-1:0]         iss_dst,
   output logic                          iss_ready,
   input  logic [WAKE_N-1:0]             wake_valid,
   input  logic [WAKE_N-1:0][TAG_W-1:0]  wake_tag,
   input  logic                          div_busy,
   input  logic                          sqrt_busy,
   output logic                          add_valid,
   output logic [TAG_W-1:0]              add_src0,
   output logic [TAG_W-1:0]              add_src1,
   output logic [TAG_W-1:0]              add_dst,
   output logic                          shr_valid,
   output logic [1:0]                    shr_unit,
   output logic [TAG_W-1:0]              shr_src0,
   output logic [TAG_W-1:0]              shr_src1,
   output logic [TAG_W-1:0]              shr_dst
);

   localparam int IDX_W = $clog2(DEPTH);
   localparam int CNT_W = $clog2(DEPTH+1);

   // elaboration-time parameter checks
   if (DEPTH < 2 || DEPTH > 64) begin : g_bad_depth
      $error("fp_shelf_dispatch: DEPTH must lie in 2..64");
   end
   if (TAG_W < 1) begin : g_bad_tag
      $error("fp_shelf_dispatch: TAG_W must be at least 1");
   end
   if (WAKE_N < 1) begin : g_bad_wake
      $error("fp_shelf_dispatch: WAKE_N must be at least 1");
   end
   if (ISSUE_N != 2) begin : g_bad_issue
      $error("fp_shelf_dispatch: issue width is fixed at two slots");
   end

   // ---------------- entry state ----------------
   logic [DEPTH-1:0]             vld_q;
   logic [DEPTH-1:0]             r0_q;
   logic [DEPTH-1:0]             r1_q;
   logic [DEPTH-1:0][DEPTH-1:0]  older_q;
   fu_e                          unit_q [DEPTH];
   logic [TAG_W-1:0]             s0_q   [DEPTH];
   logic [TAG_W-1:0]             s1_q   [DEPTH];
   logic [TAG_W-1:0]             dst_q  [DEPTH];

   // ---------------- wakeup match ----------------
   logic [DEPTH-1:0] hit0, hit1;
   logic [1:0]       ihit0, ihit1;

   for (genvar e = 0; e < DEPTH; e++) begin : g_ent_wake
      fpd_wake_match #(.TAG_W(TAG_W), .WAKE_N(WAKE_N)) u_m0 (
         .tag(s0_q[e]), .wake_valid(wake_valid), .wake_tag(wake_tag), .hit(hit0[e]));
      fpd_wake_match #(.TAG_W(TAG_W), .WAKE_N(WAKE_N)) u_m1 (
         .tag(s1_q[e]), .wake_valid(wake_valid), .wake_tag(wake_tag), .hit(hit1[e]));
   end

   for (genvar k = 0; k < ISSUE_N; k++) begin : g_iss_wake
      fpd_wake_match #(.TAG_W(TAG_W), .WAKE_N(WAKE_N)) u_m0 (
         .tag(iss_src0[k]), .wake_valid(wake_valid), .wake_tag(wake_tag), .hit(ihit0[k]));
      fpd_wake_match #(.TAG_W(TAG_W), .WAKE_N(WAKE_N)) u_m1 (
         .tag(iss_src1[k]), .wake_valid(wake_valid), .wake_tag(wake_tag), .hit(ihit1[k]));
   end

   // ---------------- eligibility ----------------
   logic [DEPTH-1:0] rdy;
   logic [DEPTH-1:0] elig_add;
   logic [DEPTH-1:0] elig_shr;

   always_comb begin
      for (int e = 0; e < DEPTH; e++) begin
         rdy[e]      = vld_q[e] & r0_q[e] & r1_q[e];
         elig_add[e] = rdy[e] & (unit_q[e] == FU_ADD);
         unique case (unit_q[e])
            FU_MUL:  elig_shr[e] = rdy[e];
            FU_DIV:  elig_shr[e] = rdy[e] & ~div_busy;
            FU_SQRT: elig_shr[e] = rdy[e] & ~sqrt_busy;
            default: elig_shr[e] = 1'b0;
         endcase
      end
   end

   // ---------------- oldest-first pick per port ----------------
   logic [DEPTH-1:0] add_grant, shr_grant;
   logic             add_found, shr_found;
   logic [IDX_W-1:0] add_idx, shr_idx;

   fpd_age_pick #(.DEPTH(DEPTH)) u_add_pick (
      .elig(elig_add), .older(older_q),
      .grant(add_grant), .found(add_found), .idx(add_idx));

   fpd_age_pick #(.DEPTH(DEPTH)) u_shr_pick (
      .elig(elig_shr), .older(older_q),
      .grant(shr_grant), .found(shr_found), .idx(shr_idx));

   assign add_valid = add_found & ~flush;
   assign add_src0  = s0_q[add_idx];
   assign add_src1  = s1_q[add_idx];
   assign add_dst   = dst_q[add_idx];

   assign shr_valid = shr_found & ~flush;
   assign shr_unit  = unit_q[shr_idx];
   assign shr_src0  = s0_q[shr_idx];
   assign shr_src1  = s1_q[shr_idx];
   assign shr_dst   = dst_q[shr_idx];

   // ---------------- issue acceptance ----------------
   logic [DEPTH-1:0] free_first, free_second;
   logic [CNT_W-1:0] free_cnt;
   logic [1:0]       req_cnt;
   logic [1:0]       acc;
   logic [DEPTH-1:0] alloc0, alloc1;
   logic [DEPTH-1:0] deq, surv;

   fpd_free_alloc #(.DEPTH(DEPTH)) u_alloc (
      .vld(vld_q), .first(free_first), .second(free_second), .free_cnt(free_cnt));

   assign req_cnt   = {1'b0, iss_valid[0]} + {1'b0, iss_valid[1]};
   assign iss_ready = ~flush & (free_cnt >= CNT_W'(req_cnt));
   assign acc       = iss_valid & {2{iss_ready}};

   always_comb begin
      alloc0 = acc[0] ? free_first : '0;
      if (!acc[1])     alloc1 = '0;
      else if (acc[0]) alloc1 = free_second;
      else             alloc1 = free_first;
   end

   assign deq  = (add_valid ? add_grant : '0) | (shr_valid ? shr_grant : '0);
   assign surv = vld_q & ~deq;

   // ---------------- control state ----------------
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vld_q   <= '0;
         r0_q    <= '0;
         r1_q    <= '0;
         older_q <= '0;
      end else if (flush) begin
         vld_q   <= '0;
      end else begin
         vld_q <= surv | alloc0 | alloc1;
         for (int e = 0; e < DEPTH; e++) begin
            if (alloc0[e]) begin
               r0_q[e]    <= iss_src0_rdy[0] | ihit0[0];
               r1_q[e]    <= iss_src1_rdy[0] | ihit1[0];
               older_q[e] <= surv;
            end else if (alloc1[e]) begin
               r0_q[e]    <= iss_src0_rdy[1] | ihit0[1];
               r1_q[e]    <= iss_src1_rdy[1] | ihit1[1];
               older_q[e] <= surv | alloc0;
            end else begin
               r0_q[e]    <= r0_q[e] | hit0[e];
               r1_q[e]    <= r1_q[e] | hit1[e];
               older_q[e] <= older_q[e] & ~(alloc0 | alloc1);
            end
         end
      end
   end

   // ---------------- payload state ----------------
   always_ff @(posedge clk) begin
      for (int e = 0; e < DEPTH; e++) begin
         if (alloc0[e]) begin
            unit_q[e] <= fu_e'(iss_unit[0]);
            s0_q[e]   <= iss_src0[0];
            s1_q[e]   <= iss_src1[0];
            dst_q[e]  <= iss_dst[0];
         end else if (alloc1[e]) begin
            unit_q[e] <= fu_e'(iss_unit[1]);
            s0_q[e]   <= iss_src0[1];
            s1_q[e]   <= iss_src1[1];
            dst_q[e]  <= iss_dst[1];
         end
      end
   end

endmodule

// File: rtl/fpd_checker.sv
`timescale 1ns/1ps
module fpd_checker (
   input logic       clk,
   input logic       rst_n,
   input logic       flush,
   input logic [1:0] iss_valid,
   input logic       iss_ready,
   input logic       div_busy,
   input logic       sqrt_busy,
   input logic       add_valid,
   input logic       shr_valid,
   input logic [1:0] shr_unit
);

   assert_reset_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (!add_valid && !shr_valid));

   assert_div_free_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (shr_valid && shr_unit == 2'b10) |-> !div_busy);

   assert_sqrt_free_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (shr_valid && shr_unit == 2'b11) |-> !sqrt_busy);

   assert_ready_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!flush && iss_valid == 2'b00) |-> iss_ready);

   assert_flush_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
      flush |-> (!add_valid && !shr_valid && !iss_ready));

   assert_flush_empty_R7: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> (!add_valid && !shr_valid));

endmodule

bind fp_shelf_dispatch fpd_checker u_fpd_checker (
   .clk       (clk),
   .rst_n     (rst_n),
   .flush     (flush),
   .iss_valid (iss_valid),
   .iss_ready (iss_ready),
   .div_busy  (div_busy),
   .sqrt_busy (sqrt_busy),
   .add_valid (add_valid),
   .shr_valid (shr_valid),
   .shr_unit  (shr_unit)
);

// File: tb/fp_shelf_dispatch_tb_top.sv
`timescale 1ns/1ps
module fp_shelf_dispatch_tb_top;

   localparam int DEPTH  = 16;
   localparam int TAG_W  = 6;
   localparam int WAKE_N = 2;

   logic                         clk = 1'b0;
   logic                         rst_n = 1'b0;
   logic                         flush = 1'b0;
   logic [1:0]                   iss_valid = '0;
   logic [1:0][1:0]              iss_unit = '0;
   logic [1:0][TAG_W-1:0]        iss_src0 = '0;
   logic [1:0]                   iss_src0_rdy = '0;
   logic [1:0][TAG_W-1:0]        iss_src1 = '0;
   logic [1:0]                   iss_src1_rdy = '0;
   logic [1:0][TAG_W-1:0]        iss_dst = '0;
   logic                         iss_ready;
   logic [WAKE_N-1:0]            wake_valid = '0;
   logic [WAKE_N-1:0][TAG_W-1:0] wake_tag = '0;
   logic                         div_busy = 1'b0;
   logic                         sqrt_busy = 1'b0;
   logic                         add_valid, shr_valid;
   logic [TAG_W-1:0]             add_src0, add_src1, add_dst;
   logic [1:0]                   shr_unit;
   logic [TAG_W-1:0]             shr_src0, shr_src1, shr_dst;

   always #5 clk = ~clk;

   fp_shelf_dispatch #(.DEPTH(DEPTH), .TAG_W(TAG_W), .WAKE_N(WAKE_N)) dut_i (
      .clk(clk), .rst_n(rst_n), .flush(flush),
      .iss_valid(iss_valid), .iss_unit(iss_unit),
      .iss_src0(iss_src0), .iss_src0_rdy(iss_src0_rdy),
      .iss_src1(iss_src1), .iss_src1_rdy(iss_src1_rdy),
      .iss_dst(iss_dst), .iss_ready(iss_ready),
      .wake_valid(wake_valid), .wake_tag(wake_tag),
      .div_busy(div_busy), .sqrt_busy(sqrt_busy),
      .add_valid(add_valid), .add_src0(add_src0), .add_src1(add_src1), .add_dst(add_dst),
      .shr_valid(shr_valid), .shr_unit(shr_unit),
      .shr_src0(shr_src0), .shr_src1(shr_src1), .shr_dst(shr_dst));

   // ---------------- staged stimulus ----------------
   logic                         nx_flush;
   logic [1:0]                   nx_iv;
   logic [1:0][1:0]              nx_unit;
   logic [1:0][TAG_W-1:0]        nx_s0, nx_s1, nx_dst;
   logic [1:0]                   nx_r0, nx_r1;
   logic [WAKE_N-1:0]            nx_wv;
   logic [WAKE_N-1:0][TAG_W-1:0] nx_wt;
   logic                         nx_dbusy, nx_sbusy;

   // ---------------- reference model: age-ordered queue ----------------
   typedef struct {
      int unit;
      int s0;
      bit r0;
      int s1;
      bit r1;
      int dst;
   } ent_t;

   ent_t mq[$];
   int   n_chk = 0;
   int   n_err = 0;
   bit   done  = 1'b0;

   task automatic chk(string req, string what, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_err++;
         $display("FAIL %s %s act=%0d exp=%0d", req, what, act, exp);
      end
   endtask

   task automatic clear_nx();
      nx_flush = 1'b0; nx_iv = '0; nx_unit = '0;
      nx_s0 = '0; nx_s1 = '0; nx_dst = '0; nx_r0 = '0; nx_r1 = '0;
      nx_wv = '0; nx_wt = '0; nx_dbusy = 1'b0; nx_sbusy = 1'b0;
   endtask

   task automatic put(int k, int u, int a, bit ar, int b, bit br, int d);
      nx_iv[k]   = 1'b1;
      nx_unit[k] = 2'(u);
      nx_s0[k]   = TAG_W'(a);
      nx_r0[k]   = ar;
      nx_s1[k]   = TAG_W'(b);
      nx_r1[k]   = br;
      nx_dst[k]  = TAG_W'(d);
   endtask

   task automatic wake(int w, int t);
      nx_wv[w] = 1'b1;
      nx_wt[w] = TAG_W'(t);
   endtask

   function automatic bit woke(int t);
      for (int w = 0; w < WAKE_N; w++)
         if (wake_valid[w] && int'(wake_tag[w]) == t) return 1'b1;
      return 1'b0;
   endfunction

   task automatic step(string lbl);
      int ea, es, req;
      bit er, rd, ok;
      ent_t ne;
      @(negedge clk);
      flush = nx_flush; iss_valid = nx_iv; iss_unit = nx_unit;
      iss_src0 = nx_s0; iss_src0_rdy = nx_r0; iss_src1 = nx_s1; iss_src1_rdy = nx_r1;
      iss_dst = nx_dst; wake_valid = nx_wv; wake_tag = nx_wt;
      div_busy = nx_dbusy; sqrt_busy = nx_sbusy;
      #1;
      ea = -1; es = -1;
      if (!flush) begin
         foreach (mq[i]) begin
            rd = mq[i].r0 && mq[i].r1;
            if (ea < 0 && rd && mq[i].unit == 0) ea = i;
            ok = (mq[i].unit == 1) || (mq[i].unit == 2 && !div_busy) ||
                 (mq[i].unit == 3 && !sqrt_busy);
            if (es < 0 && rd && ok) es = i;
         end
      end
      req = int'(iss_valid[0]) + int'(iss_valid[1]);
      er  = !flush && ((DEPTH - mq.size()) >= req);
      chk(lbl, "iss_ready", int'(iss_ready), int'(er));
      chk(lbl, "add_valid", int'(add_valid), int'(ea >= 0));
      if (ea >= 0) begin
         chk(lbl, "add_src0", int'(add_src0), mq[ea].s0);
         chk(lbl, "add_src1", int'(add_src1), mq[ea].s1);
         chk(lbl, "add_dst",  int'(add_dst),  mq[ea].dst);
      end
      chk(lbl, "shr_valid", int'(shr_valid), int'(es >= 0));
      if (es >= 0) begin
         chk(lbl, "shr_unit", int'(shr_unit), mq[es].unit);
         chk(lbl, "shr_src0", int'(shr_src0), mq[es].s0);
         chk(lbl, "shr_src1", int'(shr_src1), mq[es].s1);
         chk(lbl, "shr_dst",  int'(shr_dst),  mq[es].dst);
      end
      @(posedge clk);
      if (flush) begin
         mq.delete();
      end else begin
         foreach (mq[i]) begin
            if (woke(mq[i].s0)) mq[i].r0 = 1'b1;
            if (woke(mq[i].s1)) mq[i].r1 = 1'b1;
         end
         if (es > ea) begin
            mq.delete(es);
            if (ea >= 0) mq.delete(ea);
         end else begin
            if (ea >= 0) mq.delete(ea);
            if (es >= 0) mq.delete(es);
         end
         if (er) begin
            for (int k = 0; k < 2; k++) begin
               if (iss_valid[k]) begin
                  ne.unit = int'(iss_unit[k]);
                  ne.s0   = int'(iss_src0[k]);
                  ne.r0   = iss_src0_rdy[k] || woke(ne.s0);
                  ne.s1   = int'(iss_src1[k]);
                  ne.r1   = iss_src1_rdy[k] || woke(ne.s1);
                  ne.dst  = int'(iss_dst[k]);
                  mq.push_back(ne);
               end
            end
         end
      end
   endtask

   task automatic idle(string lbl, int n);
      for (int i = 0; i < n; i++) begin
         clear_nx();
         step(lbl);
      end
   endtask

   // ---------------- watchdog ----------------
   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_err++;
         $display("FAIL R1 watchdog act=running exp=finished");
         $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
         $finish;
      end
   end

   // ---------------- sequence ----------------
   initial begin
      clear_nx();
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      #1;
      // R1: reset state seen at the ports
      chk("R1", "add_valid", int'(add_valid), 0);
      chk("R1", "shr_valid", int'(shr_valid), 0);
      chk("R1", "iss_ready", int'(iss_ready), 1);
      idle("R1", 2);

      // R2: two ready adds, dispatched oldest first on the adder port
      clear_nx();
      put(0, 0, 1, 1, 2, 1, 10);
      put(1, 0, 3, 1, 4, 1, 11);
      step("R2");
      idle("R2", 3);

      // R3: mul, div, sqrt plus an add: one shared op per cycle, add in parallel
      clear_nx();
      put(0, 1, 5, 1, 6, 1, 20);
      put(1, 2, 7, 1, 8, 1, 21);
      step("R3");
      clear_nx();
      put(0, 3, 9, 1, 10, 1, 22);
      put(1, 0, 11, 1, 12, 1, 23);
      step("R3");
      idle("R3", 4);

      // R4: busy divider then busy square-root unit
      clear_nx();
      put(0, 2, 1, 1, 1, 1, 30);
      put(1, 3, 2, 1, 2, 1, 31);
      nx_dbusy = 1'b1;
      step("R4");
      for (int i = 0; i < 3; i++) begin
         clear_nx(); nx_dbusy = 1'b1; step("R4");
      end
      idle("R4", 2);
      clear_nx();
      put(0, 3, 3, 1, 3, 1, 32);
      put(1, 1, 4, 1, 4, 1, 33);
      nx_sbusy = 1'b1;
      step("R4");
      for (int i = 0; i < 3; i++) begin
         clear_nx(); nx_sbusy = 1'b1; step("R4");
      end
      idle("R4", 2);

      // R5: wakeup one cycle after issue, and wakeup in the issue cycle
      clear_nx();
      put(0, 1, 45, 0, 4, 1, 40);
      put(1, 0, 46, 1, 47, 0, 41);
      step("R5");
      clear_nx(); wake(0, 45); wake(1, 47);
      step("R5");
      idle("R5", 3);
      clear_nx();
      put(0, 2, 48, 0, 49, 0, 42);
      wake(0, 48); wake(1, 49);
      step("R5");
      idle("R5", 3);

      // R6: fill with waiting entries, then requests against a full buffer
      for (int i = 0; i < DEPTH / 2; i++) begin
         clear_nx();
         put(0, i % 4, 50, 0, 51, 1, 2 * i);
         put(1, (i + 1) % 4, 51, 1, 50, 0, 2 * i + 1);
         step("R6");
      end
      clear_nx(); put(0, 0, 1, 1, 1, 1, 60); put(1, 1, 1, 1, 1, 1, 61);
      step("R6");
      clear_nx(); put(1, 1, 1, 1, 1, 1, 62);
      step("R6");
      // R8: release everything, drain, and refill freed slots
      clear_nx(); wake(0, 50);
      step("R8");
      for (int i = 0; i < DEPTH; i++) begin
         clear_nx();
         put(0, i % 4, 2, 1, 3, 1, 63 - i);
         put(1, 1, 2, 1, 3, 1, i);
         step("R8");
      end
      idle("R8", 24);

      // R7: flush with waiting entries and a simultaneous issue request
      clear_nx();
      put(0, 0, 5, 1, 5, 1, 1);
      put(1, 1, 6, 1, 6, 1, 2);
      step("R7");
      clear_nx();
      nx_flush = 1'b1;
      put(0, 0, 7, 1, 7, 1, 3);
      put(1, 2, 8, 1, 8, 1, 4);
      step("R7");
      idle("R7", 3);

      // R9: distinct tags on both ports in the same cycle
      clear_nx();
      put(0, 0, 33, 1, 34, 1, 35);
      put(1, 3, 36, 1, 37, 1, 38);
      step("R9");
      idle("R9", 2);

      // random mix of issue, wakeup, busy and rare flush
      for (int n = 0; n < 3000; n++) begin
         clear_nx();
         for (int k = 0; k < 2; k++) begin
            if ($urandom_range(2) != 0)
               put(k, int'($urandom_range(3)), int'($urandom_range(7)),
                   bit'($urandom_range(1)), int'($urandom_range(7)),
                   bit'($urandom_range(1)), int'($urandom_range(63)));
         end
         for (int w = 0; w < WAKE_N; w++)
            if ($urandom_range(1) != 0) wake(w, int'($urandom_range(7)));
         nx_dbusy = ($urandom_range(3) == 0);
         nx_sbusy = ($urandom_range(3) == 0);
         nx_flush = ($urandom_range(199) == 0);
         step("R3");
      end
      idle("R8", 20);

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end

endmodule